// File: doc/BRIEF.md
# Serial Configuration Image Loader

After reset this block fills the chip's internal register file and RAM from an external serial EEPROM. It drives the EEPROM as an SPI master and issues one read command that starts at byte 0. It then lets the data stream out. Every two bytes form one 16-bit word, and each word is written to the internal address that matches its position in the stream.

Each word is checked in two ways. First, the written word is read back from internal memory and compared with the value that was written. Second, the word is added into a 16-bit running tally. The tally skips four volatile registers. The checksum slot at word 0x020 contributes only the value stored in the EEPROM. A correct image leaves the tally at zero. A strap input selects either the short image range or the long image range.

The `ready` output stays low until the last word has been handled. In its first high cycle the stored checksum is copied into the slot. The block also reports a checksum-fail flag, a read-back-error flag and the address of the first read-back mismatch. A second strap, sampled as reset ends, can skip the whole sequence.

Top module: `cfg_image_loader`

## Requirements
- R1: If `auto_en` is low when reset ends, `ready` goes high within four clock cycles. In that case `spi_cs_n` never goes low, the memory port is never enabled, and both error flags stay low.
- R2: The SPI transfer uses mode 0: `spi_sck` idles low, MOSI is sampled on the rising edge, and the data is MSB first. Chip select goes low exactly once per load. The first 24 bits shifted out are the read command 0x03 followed by the 16-bit byte address 0x0000.
- R3: EEPROM bytes 2n (high byte) and 2n+1 (low byte) form word n, and word n is written to internal address n. The only exception is the checksum slot (R8).
- R4: With `short_sel` high the load covers word addresses 0 to SHORT_WORDS-1 (0x000 to 0x3FF by default). With it low the load covers 0 to LONG_WORDS-1 (0x0000 to 0x7FFF by default). Addresses outside the selected range are never written.
- R5: Every word written during the load is read from the same address in the next cycle. The returned data is compared one cycle after that, and any difference sets `rb_err`.
- R6: `rb_err_addr` holds the address of the first mismatch. Later mismatches do not change it.
- R7: The tally is a 16-bit modular sum of the words as received from the EEPROM. If the final tally is nonzero, `ck_fail` is set. The flag changes only at the moment `ready` rises.
- R8: Word address 0x020 adds only its EEPROM value to the tally, so its memory contents count as zero. It is not written or read back during the load.
- R9: Word addresses 0x002, 0x006, 0x008 and 0x014 are written and read back but are left out of the tally.
- R10: `ready` is low for the whole load and rises after the last word has been handled. Once high, it stays high until reset, and `spi_cs_n` is then high.
- R11: In the first cycle that `ready` is high after a load, the EEPROM value of the checksum slot is written to address 0x020. This is the only write the block makes while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Strap that enables the load, sampled as reset ends |
| short_sel | input | 1 | Strap: high selects the short range, low the long range |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the EEPROM |
| spi_miso | input | 1 | SPI data from the EEPROM |
| mem_en | output | 1 | Internal memory access enable |
| mem_we | output | 1 | Internal memory write enable |
| mem_addr | output | ADDR_W | Internal memory word address |
| mem_wdata | output | 16 | Internal memory write data |
| mem_rdata | input | 16 | Internal memory read data, one cycle after a read |
| ready | output | 1 | High once the load is complete or skipped |
| ck_fail | output | 1 | Final tally was nonzero |
| rb_err | output | 1 | At least one read-back mismatch occurred |
| rb_err_addr | output | ADDR_W | Address of the first read-back mismatch |

## Verification
The rise of `ready` and the checksum-slot write fall in the same cycle. In that same cycle the checksum verdict also becomes visible. The bench watches memory writes to 0x020 on the falling clock edge and records `ready` at that moment. It expects exactly one such write, and expects that write to occur with `ready` already high. This is provoked hardest by corrupting the read-back of the final word and breaking the checksum in the same run. The bench then expects both flags, the captured last address and the slot write all to appear together with `ready`.

// File: rtl/cil_pkg.sv
package cil_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned HDR_BITS = 24;
  localparam logic [7:0]  READ_CMD = 8'h03;
  localparam logic [15:0] SLOT_ADDR = 16'h0020;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRAIN,
    ST_POST,
    ST_DONE
  } seq_state_e;

  // Volatile registers kept out of the tally (R9)
  function automatic logic untallied(input logic [15:0] a);
    return (a == 16'h0002) || (a == 16'h0006) ||
           (a == 16'h0008) || (a == 16'h0014);
  endfunction
endpackage

// File: rtl/cil_rst_sync.sv
module cil_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cil_spi_stream.sv
module cil_spi_stream
  import cil_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] last_idx,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              busy,
  output logic              word_v,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned HC_W = $clog2(HDR_BITS);
  localparam int unsigned BC_W = $clog2(WORD_W);

  logic              active_q, active_d;
  logic              sck_q, sck_d;
  logic              stop_q, stop_d;
  logic              hdr_done_q, hdr_done_d;
  logic [HC_W-1:0]   hdr_cnt_q, hdr_cnt_d;
  logic [BC_W-1:0]   bit_cnt_q, bit_cnt_d;
  logic [HDR_BITS-1:0] sh_out_q, sh_out_d;
  logic [WORD_W-2:0] sh_in_q, sh_in_d;
  logic [ADDR_W-1:0] wcnt_q, wcnt_d;
  logic              word_v_q, word_v_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              rise, fall;

  assign rise = active_q && !sck_q;
  assign fall = active_q &&  sck_q;

  always_comb begin
    active_d   = active_q;
    sck_d      = sck_q;
    stop_d     = stop_q;
    hdr_done_d = hdr_done_q;
    hdr_cnt_d  = hdr_cnt_q;
    bit_cnt_d  = bit_cnt_q;
    sh_out_d   = sh_out_q;
    sh_in_d    = sh_in_q;
    wcnt_d     = wcnt_q;
    word_v_d   = 1'b0;
    word_d     = word_q;
    if (start && !active_q) begin
      active_d   = 1'b1;
      sck_d      = 1'b0;
      stop_d     = 1'b0;
      hdr_done_d = 1'b0;
      hdr_cnt_d  = '0;
      bit_cnt_d  = '0;
      wcnt_d     = '0;
      sh_out_d   = {READ_CMD, 16'h0000};
    end else if (rise) begin
      sck_d = 1'b1;
      if (!hdr_done_q) begin
        hdr_cnt_d = hdr_cnt_q + 1'b1;
        if (hdr_cnt_q == HC_W'(HDR_BITS - 1)) hdr_done_d = 1'b1;
      end else begin
        sh_in_d   = {sh_in_q[WORD_W-3:0], spi_miso};
        bit_cnt_d = bit_cnt_q + 1'b1;
        if (bit_cnt_q == BC_W'(WORD_W - 1)) begin
          word_v_d = 1'b1;
          word_d   = {sh_in_q, spi_miso};
          wcnt_d   = wcnt_q + 1'b1;
          if (wcnt_q == last_idx) stop_d = 1'b1;
        end
      end
    end else if (fall) begin
      sck_d    = 1'b0;
      sh_out_d = {sh_out_q[HDR_BITS-2:0], 1'b0};
      if (stop_q) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      sck_q      <= 1'b0;
      stop_q     <= 1'b0;
      hdr_done_q <= 1'b0;
      hdr_cnt_q  <= '0;
      bit_cnt_q  <= '0;
      sh_out_q   <= '0;
      sh_in_q    <= '0;
      wcnt_q     <= '0;
      word_v_q   <= 1'b0;
      word_q     <= '0;
    end else begin
      active_q   <= active_d;
      sck_q      <= sck_d;
      stop_q     <= stop_d;
      hdr_done_q <= hdr_done_d;
      hdr_cnt_q  <= hdr_cnt_d;
      bit_cnt_q  <= bit_cnt_d;
      sh_out_q   <= sh_out_d;
      sh_in_q    <= sh_in_d;
      wcnt_q     <= wcnt_d;
      word_v_q   <= word_v_d;
      word_q     <= word_d;
    end
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = ~active_q;
  assign spi_mosi = sh_out_q[HDR_BITS-1];
  assign busy     = active_q;
  assign word_v   = word_v_q;
  assign word     = word_q;

  // R2: mode 0 clock idles low whenever the device is deselected
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck)
    else $error("R2: sck high while deselected");

  // R2: a word is only delivered while the transfer is open
  a_r2_word_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    word_v |-> !spi_cs_n)
    else $error("R2: word delivered outside frame");
endmodule

// File: rtl/cil_seq.sv
module cil_seq
  import cil_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned LONG_WORDS  = 32768,
  parameter int unsigned SHORT_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              short_sel,
  input  logic              word_v,
  input  logic [WORD_W-1:0] word,
  input  logic              busy,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              start,
  output logic [ADDR_W-1:0] last_idx,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ready,
  output logic              ck_fail,
  output logic              rb_err,
  output logic [ADDR_W-1:0] rb_err_addr
);
  localparam logic [ADDR_W-1:0] LONG_LAST  = ADDR_W'(LONG_WORDS - 1);
  localparam logic [ADDR_W-1:0] SHORT_LAST = ADDR_W'(SHORT_WORDS - 1);
  localparam logic [ADDR_W-1:0] SLOT       = ADDR_W'(SLOT_ADDR);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] tally_q, tally_d;
  logic [WORD_W-1:0] ck_word_q, ck_word_d;
  logic              wr_v_q, wr_v_d;
  logic              rd_v_q, rd_v_d;
  logic              cmp_v_q, cmp_v_d;
  logic [ADDR_W-1:0] pipe_addr_q, pipe_addr_d;
  logic [WORD_W-1:0] pipe_data_q, pipe_data_d;
  logic              ready_q, ready_d;
  logic              ck_fail_q, ck_fail_d;
  logic              rb_err_q, rb_err_d;
  logic [ADDR_W-1:0] rb_addr_q, rb_addr_d;
  logic              post;

  always_comb begin
    state_d     = state_q;
    last_d      = last_q;
    addr_d      = addr_q;
    tally_d     = tally_q;
    ck_word_d   = ck_word_q;
    wr_v_d      = 1'b0;
    rd_v_d      = wr_v_q;   // R5: read follows the write
    cmp_v_d     = rd_v_q;   // R5: compare follows the read
    pipe_addr_d = pipe_addr_q;
    pipe_data_d = pipe_data_q;
    ready_d     = ready_q;
    ck_fail_d   = ck_fail_q;
    rb_err_d    = rb_err_q;
    rb_addr_d   = rb_addr_q;
    start       = 1'b0;

    if (cmp_v_q && (mem_rdata != pipe_data_q)) begin
      rb_err_d = 1'b1;
      if (!rb_err_q) rb_addr_d = pipe_addr_q;   // R6
    end

    unique case (state_q)
      ST_IDLE: begin
        if (auto_en) begin
          start   = 1'b1;
          last_d  = short_sel ? SHORT_LAST : LONG_LAST;   // R4
          addr_d  = '0;
          tally_d = '0;
          state_d = ST_LOAD;
        end else begin
          ready_d = 1'b1;                                 // R1
          state_d = ST_DONE;
        end
      end
      ST_LOAD: begin
        if (word_v) begin
          addr_d = addr_q + 1'b1;
          if (!untallied(16'(addr_q))) tally_d = tally_q + word;  // R7, R9
          if (addr_q == SLOT) begin
            ck_word_d = word;                             // R8
          end else begin
            wr_v_d      = 1'b1;                           // R3
            pipe_addr_d = addr_q;
            pipe_data_d = word;
          end
          if (addr_q == last_q) state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!busy && !wr_v_q && !rd_v_q && !cmp_v_q) begin
          ready_d   = 1'b1;                               // R10
          ck_fail_d = (tally_q != '0);                    // R7
          state_d   = ST_POST;
        end
      end
      ST_POST: state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      last_q      <= '0;
      addr_q      <= '0;
      tally_q     <= '0;
      ck_word_q   <= '0;
      wr_v_q      <= 1'b0;
      rd_v_q      <= 1'b0;
      cmp_v_q     <= 1'b0;
      pipe_addr_q <= '0;
      pipe_data_q <= '0;
      ready_q     <= 1'b0;
      ck_fail_q   <= 1'b0;
      rb_err_q    <= 1'b0;
      rb_addr_q   <= '0;
    end else begin
      state_q     <= state_d;
      last_q      <= last_d;
      addr_q      <= addr_d;
      tally_q     <= tally_d;
      ck_word_q   <= ck_word_d;
      wr_v_q      <= wr_v_d;
      rd_v_q      <= rd_v_d;
      cmp_v_q     <= cmp_v_d;
      pipe_addr_q <= pipe_addr_d;
      pipe_data_q <= pipe_data_d;
      ready_q     <= ready_d;
      ck_fail_q   <= ck_fail_d;
      rb_err_q    <= rb_err_d;
      rb_addr_q   <= rb_addr_d;
    end
  end

  // R11: slot copy happens in the first ready cycle
  assign post      = (state_q == ST_POST);
  assign mem_en    = wr_v_q | rd_v_q | post;
  assign mem_we    = wr_v_q | post;
  assign mem_addr  = post ? SLOT : pipe_addr_q;
  assign mem_wdata = post ? ck_word_q : pipe_data_q;
  assign last_idx    = last_q;
  assign ready       = ready_q;
  assign ck_fail     = ck_fail_q;
  assign rb_err      = rb_err_q;
  assign rb_err_addr = rb_addr_q;

  // R6: first mismatch address is held once captured
  a_r6_first_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    rb_err |=> (rb_err && $stable(rb_err_addr)))
    else $error("R6: captured address moved");

  // R4: no access beyond the selected range
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr <= last_q))
    else $error("R4: access outside range");

  // R7: checksum verdict only visible together with ready
  a_r7_verdict_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ck_fail |-> ready)
    else $error("R7: checksum flag before ready");
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cil_pkg::*;
#(
  parameter int unsigned LONG_WORDS  = 32768,
  parameter int unsigned SHORT_WORDS = 1024,
  parameter int unsigned ADDR_W      = $clog2(LONG_WORDS),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              short_sel,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              ready,
  output logic              ck_fail,
  output logic              rb_err,
  output logic [ADDR_W-1:0] rb_err_addr
);
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_ADDR);

  logic              rst_s;
  logic              start;
  logic [ADDR_W-1:0] last_idx;
  logic              busy;
  logic              word_v;
  logic [WORD_W-1:0] word;

  cil_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_s)
  );

  cil_spi_stream #(.ADDR_W(ADDR_W)) u_spi (
    .clk     (clk),
    .rst_n   (rst_s),
    .start   (start),
    .last_idx(last_idx),
    .spi_miso(spi_miso),
    .spi_sck (spi_sck),
    .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi),
    .busy    (busy),
    .word_v  (word_v),
    .word    (word)
  );

  cil_seq #(
    .ADDR_W     (ADDR_W),
    .LONG_WORDS (LONG_WORDS),
    .SHORT_WORDS(SHORT_WORDS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_s),
    .auto_en    (auto_en),
    .short_sel  (short_sel),
    .word_v     (word_v),
    .word       (word),
    .busy       (busy),
    .mem_rdata  (mem_rdata),
    .start      (start),
    .last_idx   (last_idx),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .ready      (ready),
    .ck_fail    (ck_fail),
    .rb_err     (rb_err),
    .rb_err_addr(rb_err_addr)
  );

  // R10: ready never drops before reset
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    ready |=> ready)
    else $error("R10: ready dropped");

  // R10: bus is released whenever ready is high
  a_r10_bus_idle: assert property (@(posedge clk) disable iff (!rst_s)
    ready |-> spi_cs_n)
    else $error("R10: SPI active with ready high");

  // R5: a load write is followed by a read of the same address
  a_r5_readback_follows: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_en && mem_we && !ready) |=>
      (mem_en && !mem_we && mem_addr == $past(mem_addr)))
    else $error("R5: read-back missing");

  // R11: the slot is written only with ready high
  a_r11_slot_after_ready: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_en && mem_we && mem_addr == SLOT) |-> ready)
    else $error("R11: slot written before ready");
endmodule

// File: tb/cfg_image_loader_tb.sv
module cfg_image_loader_tb_top;
  localparam int LW = 128;
  localparam int SW = 64;
  localparam int AW = 7;
  localparam int SLOT = 32;

  logic clk, rst_n, auto_en, short_sel;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr, rb_err_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic ready, ck_fail, rb_err;

  int checks = 0;
  int errors = 0;

  cfg_image_loader #(.LONG_WORDS(LW), .SHORT_WORDS(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .short_sel(short_sel),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ready(ready), .ck_fail(ck_fail), .rb_err(rb_err),
    .rb_err_addr(rb_err_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // serial EEPROM model
  logic [15:0] img [0:LW-1];
  logic [23:0] hdr;
  int hdr_n, obit, cs_falls;
  initial begin spi_miso = 1'b0; hdr_n = 0; obit = 0; cs_falls = 0; hdr = '0; end
  always @(negedge spi_cs_n) begin hdr_n = 0; obit = 0; cs_falls++; end
  always @(posedge spi_sck) if (!spi_cs_n && hdr_n < 24) begin
    hdr = {hdr[22:0], spi_mosi}; hdr_n++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && hdr_n == 24) begin
    spi_miso = img[(obit / 16) % LW][15 - (obit % 16)]; obit++;
  end

  // internal memory model with read fault injection
  logic [15:0] mem [0:LW-1];
  logic flt_on;
  logic [AW-1:0] flt_a, flt_b;
  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else mem_rdata <= mem[mem_addr] ^
      ((flt_on && (mem_addr == flt_a || mem_addr == flt_b)) ? 16'h0100 : 16'h0000);
  end

  // port monitors
  int slot_wr_n, bus_viol, late_wr, mem_acc;
  logic slot_wr_rdy;
  always @(negedge clk) if (rst_n) begin
    if (mem_en) mem_acc++;
    if (mem_en && mem_we && mem_addr == AW'(SLOT)) begin slot_wr_n++; slot_wr_rdy = ready; end
    if (ready && !spi_cs_n) bus_viol++;
    if (ready && mem_en && mem_we && mem_addr != AW'(SLOT)) late_wr++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit skip(input int a);
    return (a == 2) || (a == 6) || (a == 8) || (a == 20);
  endfunction

  task automatic build(input int seed, input int n, input bit good);
    logic [15:0] sum = 16'h0;
    for (int i = 0; i < LW; i++) img[i] = 16'(i * 40503 + seed * 7919 + (i >> 3) * 77);
    for (int i = 0; i < n; i++) if (i != SLOT && !skip(i)) sum = sum + img[i];
    img[SLOT] = (~sum) + 16'(good ? 1 : 2);
  endtask

  logic ready_mid;
  task automatic run(input bit ae, input bit ss);
    rst_n = 1'b0; auto_en = ae; short_sel = ss;
    for (int i = 0; i < LW; i++) mem[i] = 16'hC0DE ^ 16'(i);
    repeat (3) @(negedge clk);
    slot_wr_n = 0; bus_viol = 0; late_wr = 0; mem_acc = 0; cs_falls = 0; slot_wr_rdy = 1'b0;
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    ready_mid = ready;
    for (int c = 0; c < 20000 && !ready; c++) @(negedge clk);
    chk(ready, "R10 load completes", 32'(ready), 32'h1);
    repeat (10) @(negedge clk);
  endtask

  task automatic check_mem(input int n, input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < LW; i++) begin
      logic [15:0] e = (i < n) ? img[i] : (16'hC0DE ^ 16'(i));
      if (mem[i] !== e) begin bad++; if (first < 0) first = i; end
    end
    chk(bad == 0, tag, 32'(first), 32'hFFFF_FFFF);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; auto_en = 1'b0; short_sel = 1'b1; flt_on = 1'b0; flt_a = '0; flt_b = '0;
    build(1, SW, 1'b1);

    // R1: strap off, nothing happens
    rst_n = 1'b0;
    for (int i = 0; i < LW; i++) mem[i] = 16'hC0DE ^ 16'(i);
    repeat (3) @(negedge clk);
    chk(!ready, "R1 reset state ready low", 32'(ready), 32'h0);
    mem_acc = 0; cs_falls = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready, "R1 ready within four cycles", 32'(ready), 32'h1);
    repeat (50) @(negedge clk);
    chk(cs_falls == 0 && mem_acc == 0, "R1 no SPI or memory access", 32'(cs_falls + mem_acc), 32'h0);
    chk(!ck_fail && !rb_err, "R1 flags low", {30'h0, ck_fail, rb_err}, 32'h0);
    check_mem(0, "R1 memory untouched");

    // R2 R3 R4 R8 R10 R11: short range, good image
    build(1, SW, 1'b1);
    run(1'b1, 1'b1);
    chk(!ready_mid, "R10 ready low mid-load", 32'(ready_mid), 32'h0);
    chk(cs_falls == 1, "R2 single chip select", 32'(cs_falls), 32'h1);
    chk(hdr == 24'h030000, "R2 read command and address", 32'(hdr), 32'h030000);
    check_mem(SW, "R3 R4 short image placed");
    chk(!ck_fail, "R8 good image with slot tallies to zero", 32'(ck_fail), 32'h0);
    chk(!rb_err, "R5 no mismatch", 32'(rb_err), 32'h0);
    chk(slot_wr_n == 1 && slot_wr_rdy, "R11 slot written once with ready",
        32'(slot_wr_n * 2 + int'(slot_wr_rdy)), 32'h3);
    chk(bus_viol == 0 && late_wr == 0, "R10 quiet after ready", 32'(bus_viol + late_wr), 32'h0);

    // R4: long range
    build(2, LW, 1'b1);
    run(1'b1, 1'b0);
    check_mem(LW, "R4 long image placed");
    chk(!ck_fail && !rb_err, "R7 long image clean", {30'h0, ck_fail, rb_err}, 32'h0);

    // R7: wrong checksum
    build(3, SW, 1'b0);
    run(1'b1, 1'b1);
    chk(ck_fail, "R7 bad sum flagged", 32'(ck_fail), 32'h1);
    check_mem(SW, "R3 data written despite bad sum");

    // R9: excluded registers do not disturb the tally
    build(4, SW, 1'b1);
    img[20] = img[20] ^ 16'h5A5A; img[2] = img[2] + 16'h0011;
    img[6] = ~img[6]; img[8] = img[8] + 16'h0100;
    run(1'b1, 1'b1);
    chk(!ck_fail, "R9 excluded words ignored by tally", 32'(ck_fail), 32'h0);
    chk(mem[20] == img[20], "R9 excluded word still written", 32'(mem[20]), 32'(img[20]));

    // R8: the slot value itself is part of the tally
    build(5, SW, 1'b1);
    img[SLOT] = img[SLOT] + 16'h0003;
    run(1'b1, 1'b1);
    chk(ck_fail, "R8 altered slot breaks tally", 32'(ck_fail), 32'h1);
    chk(mem[SLOT] == img[SLOT], "R11 slot holds stored value", 32'(mem[SLOT]), 32'(img[SLOT]));

    // R5 R6: two faults, lower address first
    build(6, SW, 1'b1);
    flt_on = 1'b1; flt_a = 7'd5; flt_b = 7'd40;
    run(1'b1, 1'b1);
    chk(rb_err, "R5 mismatch flagged", 32'(rb_err), 32'h1);
    chk(rb_err_addr == 7'd5, "R6 first address kept", 32'(rb_err_addr), 32'd5);
    chk(!ck_fail, "R7 tally uses serial data", 32'(ck_fail), 32'h0);

    // R6: faults listed in reverse order
    flt_a = 7'd40; flt_b = 7'd9;
    run(1'b1, 1'b1);
    chk(rb_err_addr == 7'd9, "R6 earliest in stream", 32'(rb_err_addr), 32'd9);

    // R8: slot is not read back during the load
    flt_a = AW'(SLOT); flt_b = AW'(SLOT);
    run(1'b1, 1'b1);
    chk(!rb_err, "R8 slot not verified in load", 32'(rb_err), 32'h0);

    // last word faulted and bad sum together
    build(7, SW, 1'b0);
    flt_a = 7'd63; flt_b = 7'd63;
    run(1'b1, 1'b1);
    chk(rb_err && rb_err_addr == 7'd63, "R5 R6 last word mismatch", 32'(rb_err_addr), 32'd63);
    chk(ck_fail, "R7 bad sum with last fault", 32'(ck_fail), 32'h1);
    chk(slot_wr_n == 1 && slot_wr_rdy, "R11 slot write with ready", 32'(slot_wr_n), 32'h1);
    flt_on = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule